// File: doc/BRIEF.md
# Alarm Indication Signal Detector

This block watches a received line bit stream for the all-ones alarm pattern. Each cycle where the bit strobe is high carries one received bit. The block splits the stream into back-to-back windows of a fixed number of bit periods and counts the zeros in each one. A window with too few zeros means the far end is sending the alarm pattern, and the block sets a sticky status bit.

The status bit does not follow the line directly. Once set, it stays high after the stream returns to normal traffic. It drops only when the host reads the status and the most recent completed window showed normal zero density. A read while the alarm pattern is still present leaves the bit set. Decoding of the register bus lies outside the block; only a one-cycle read strobe comes in.

Top module: `ais_detector`

## Requirements
- R1: A window spans WINDOW_LEN (default 8192) bit periods. Only cycles with `bit_en_i` high advance it. Windows follow one another without overlap, and the first one begins at reset release.
- R2: A window holding fewer than ZERO_MIN (default 9) zeros sets `ais_o` to 1 in the cycle after that window's last strobe. A zero is a strobed bit with `bit_i` = 0, and the last bit of the window counts. Exactly 8 zeros sets the alarm.
- R3: A window holding ZERO_MIN or more zeros does not set `ais_o`. Exactly 9 zeros does not set the alarm.
- R4: When `ais_o` is 1 and the most recent completed window held at least ZERO_MIN zeros, a cycle with `rd_i` high clears `ais_o` in the next cycle. Until that read, `ais_o` stays at 1.
- R5: A read does not clear `ais_o` when the most recent completed window held fewer than ZERO_MIN zeros. A read in the same cycle as a window's last strobe is judged against the window before it. If a later window brings the alarm back before a read, the bit stays set.
- R6: `bit_i` is ignored while `bit_en_i` is low. `ais_o` changes only after a window's last strobe or after a read.
- R7: While `rst_ni` is low, `ais_o` is 0 and the window and zero counts return to their start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | High for one cycle per received bit period |
| bit_i | input | 1 | Received bit, valid when bit_en_i is high |
| rd_i | input | 1 | Host read strobe for the status bit |
| ais_o | output | 1 | Sticky alarm indication status |

## Verification
The bench checks the threshold from both sides. Windows with exactly 8 and exactly 9 zeros are sent, each with a zero in the final bit position. A design with an off-by-one compare, or one that drops the last bit of a window, gives the wrong verdict on one of them. Idle cycles carrying zeros are placed inside a window; a design that counts them misses an alarm it should raise. The bench also sends reads while the alarm is active, reads in the same cycle as a clearing window's last bit, and an alarm that comes back before any read; a design that clears on any read drops the status early. A reset in the middle of a window shows whether window timing really restarts, since a leftover count ends the first window early.

// File: rtl/aisd_pkg.sv
package aisd_pkg;
  typedef struct packed {
    logic done;  // last strobe of a window
    logic low;   // that window held fewer zeros than the threshold
  } win_res_t;
endpackage

// File: rtl/aisd_window_ctr.sv
module aisd_window_ctr #(
  parameter int WINDOW_LEN = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic win_end_o
);
  localparam int CW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_LEN - 1);

  logic [CW-1:0] pos_q;

  assign win_end_o = bit_en_i && (pos_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (win_end_o) pos_q <= '0;
    else if (bit_en_i)  pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/aisd_zero_ctr.sv
module aisd_zero_ctr
  import aisd_pkg::*;
#(
  parameter int ZERO_MIN = 9
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  logic     bit_i,
  input  logic     win_end_i,
  output win_res_t res_o
);
  localparam int ZW = $clog2(ZERO_MIN + 1);

  logic [ZW-1:0] zcnt_q;
  logic          is_zero;
  logic [ZW:0]   zcnt_incl;

  assign is_zero   = bit_en_i && !bit_i;
  // count including the bit strobed in this cycle
  assign zcnt_incl = {1'b0, zcnt_q} + (ZW+1)'(is_zero);

  assign res_o.done = win_end_i;
  assign res_o.low  = win_end_i && (zcnt_incl < (ZW+1)'(ZERO_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   zcnt_q <= '0;
    else if (win_end_i)                            zcnt_q <= '0;
    else if (is_zero && zcnt_q < ZW'(ZERO_MIN))    zcnt_q <= zcnt_q + 1'b1;
  end
endmodule

// File: rtl/aisd_status.sv
module aisd_status
  import aisd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  win_res_t res_i,
  input  logic     rd_i,
  output logic     cond_o,
  output logic     ais_o
);
  logic cond_q, ais_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      ais_q  <= 1'b0;
    end else begin
      if (res_i.done) cond_q <= res_i.low;
      // set wins; clear judged on the last completed window
      if (res_i.done && res_i.low) ais_q <= 1'b1;
      else if (rd_i && !cond_q)    ais_q <= 1'b0;
    end
  end

  assign cond_o = cond_q;
  assign ais_o  = ais_q;
endmodule

// File: rtl/ais_detector.sv
module ais_detector
  import aisd_pkg::*;
#(
  parameter int WINDOW_LEN = 8192,
  parameter int ZERO_MIN   = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  input  logic rd_i,
  output logic ais_o
);
  logic     win_end;
  win_res_t win_res;
  logic     cond_q;

  aisd_window_ctr #(.WINDOW_LEN(WINDOW_LEN)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .win_end_o(win_end)
  );

  aisd_zero_ctr #(.ZERO_MIN(ZERO_MIN)) u_zero (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .win_end_i(win_end), .res_o(win_res)
  );

  aisd_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .res_i(win_res), .rd_i(rd_i),
    .cond_o(cond_q), .ais_o(ais_o)
  );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
  parameter int WINDOW_LEN = 8192
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic rd_i,
  input logic ais_o,
  input logic win_end,
  input logic win_low,
  input logic cond_q
);
  localparam int CW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;

  logic [CW-1:0] strobes_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       strobes_q <= '0;
    else if (bit_en_i) strobes_q <= (strobes_q == CW'(WINDOW_LEN - 1)) ? '0 : strobes_q + 1'b1;
  end

  p_window_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end == (bit_en_i && strobes_q == CW'(WINDOW_LEN - 1)));

  p_rise_on_low_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end && win_low) |=> ais_o);

  p_fall_needs_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_o && !rd_i) |=> ais_o);

  p_read_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ais_o && cond_q) |=> ais_o);

  p_quiet_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_end && !rd_i) |=> $stable(ais_o));

  always @(negedge clk_i) if (!rst_ni) p_reset_clear_r7: assert (!ais_o);
endmodule

bind ais_detector ais_detector_chk #(.WINDOW_LEN(WINDOW_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .rd_i(rd_i),
  .ais_o(ais_o), .win_end(win_end), .win_low(win_res.low), .cond_q(cond_q)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
  localparam int WIN = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_v = 1'b1, rd = 1'b0;
  logic ais;
  int n_run = 0, n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  ais_detector #(.WINDOW_LEN(WIN), .ZERO_MIN(9)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v),
    .rd_i(rd), .ais_o(ais)
  );

  task automatic check(input logic exp, input string tag);
    n_run++;
    if (ais !== exp) begin
      n_fail++;
      $display("FAIL %s: ais_o=%b expected %b", tag, ais, exp);
    end
  endtask

  // one window; zeros placed in the last nz positions; optional idle gaps carrying zeros
  task automatic send_window(input int nz, input bit gaps, input bit rd_last);
    for (int i = 0; i < WIN; i++) begin
      if (gaps && (i % 1000 == 500)) begin
        for (int g = 0; g < 3; g++) begin
          bit_en = 1'b0; bit_v = 1'b0; @(negedge clk);
        end
      end
      bit_en = 1'b1;
      bit_v  = (i >= WIN - nz) ? 1'b0 : 1'b1;
      rd     = rd_last && (i == WIN - 1);
      @(negedge clk);
    end
    bit_en = 1'b0; bit_v = 1'b1; rd = 1'b0;
  endtask

  task automatic pulse_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    check(1'b0, "R7 reset value");
  endtask

  task automatic t_threshold();
    send_window(9, 1'b0, 1'b0);
    check(1'b0, "R3 nine zeros");
    send_window(8, 1'b1, 1'b0);
    check(1'b1, "R2 eight zeros with idle gaps (R6)");
  endtask

  task automatic t_read_active();
    pulse_read();
    check(1'b1, "R5 read during alarm");
  endtask

  task automatic t_clear();
    send_window(20, 1'b0, 1'b0);
    check(1'b1, "R4 held until read");
    repeat (5) @(negedge clk);
    check(1'b1, "R6 idle hold");
    pulse_read();
    check(1'b0, "R4 read clears");
    pulse_read();
    check(1'b0, "R4 read when clear");
  endtask

  task automatic t_same_cycle_read();
    send_window(0, 1'b0, 1'b0);
    check(1'b1, "R2 all ones");
    send_window(9, 1'b0, 1'b1);
    check(1'b1, "R5 read on clearing window end");
    pulse_read();
    check(1'b0, "R4 later read clears");
  endtask

  task automatic t_reappear();
    send_window(0, 1'b0, 1'b0);
    send_window(12, 1'b0, 1'b0);
    send_window(3, 1'b0, 1'b0);
    pulse_read();
    check(1'b1, "R5 alarm returned before read");
    send_window(9, 1'b0, 1'b0);
    pulse_read();
    check(1'b0, "R4 clear after return");
  endtask

  task automatic t_reset_restart();
    for (int i = 0; i < 4000; i++) begin
      bit_en = 1'b1; bit_v = 1'b1; @(negedge clk);
    end
    bit_en = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    check(1'b0, "R7 reset mid window");
    rst_n = 1'b1; @(negedge clk);
    for (int i = 0; i < WIN - 1; i++) begin
      bit_en = 1'b1; bit_v = 1'b1; @(negedge clk);
    end
    bit_en = 1'b0;
    check(1'b0, "R1 window not yet complete");
    bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
    check(1'b1, "R1 window completes on strobe 8192");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_threshold();
    t_read_active();
    t_clear();
    t_same_cycle_read();
    t_reappear();
    t_reset_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule